// File: doc/BRIEF.md
# SDRAM Block FIFO Slot Arbiter

This block turns an external SDRAM into a deep first-in first-out store. Data moves in and out only as whole 16-word blocks. Time on the memory is cut into fixed slots of SLOT_LEN cycles, 21 by default. A downstream burst sequencer runs the SDRAM commands for each slot. One cycle before a new slot begins, this arbiter chooses the slot's job: move one block from the input staging buffer into the SDRAM, move one block from the SDRAM into the output staging buffer, run an auto-refresh, or do nothing. It tells the sequencer which block address to use.

The arbiter keeps a write pointer, a read pointer and a count of stored blocks, all measured in blocks. The pointers wrap modulo the capacity, which is 2**BLK_W blocks. A pointer's low BANK_BITS bits are the SDRAM bank, so consecutive blocks fall in different banks. Refresh is driven by a timer. When the timer has not expired and no data move is possible, the slot is a pure NOP, which saves power.

The fill level of the input staging FIFO and the free space of the output staging FIFO come in as word counts. The decision is announced by a one-cycle `slot_start` pulse. The operation code and address that go with it stay stable until the next pulse.

Top module: `sdram_fifo_arbiter`

## Requirements
- R1: `slot_start` is high for exactly one cycle every SLOT_LEN cycles. The first pulse follows the first rising clock edge after reset is released.
- R2: `slot_op` uses the encoding 0 = idle, 1 = write block, 2 = read block, 3 = refresh. It changes only together with a `slot_start` pulse. During reset `slot_start` is 0, `slot_op` is 0 and the address is 0.
- R3: A refresh timer counts REF_INTERVAL cycles. Once it has expired, the next decision is a refresh, whatever data moves are possible. Granting the refresh reloads the timer.
- R4: If the timer has not expired and neither a write nor a read is eligible, the slot is idle.
- R5: A write is eligible when `in_level` is at least BLOCK_WORDS and the stored block count is below capacity.
- R6: A read is eligible when at least one block is stored and `out_space` is at least BLOCK_WORDS.
- R7: When both a write and a read are eligible, the arbiter chooses the opposite of the last data operation it granted. The first such choice after reset is a write.
- R8: A write slot carries the write pointer and a read slot carries the read pointer. Each grant advances its pointer by one block, modulo 2**BLK_W. Idle and refresh slots carry address 0.
- R9: `slot_bank` is the low BANK_BITS bits of the block address, and `slot_row` is the remaining upper bits.
- R10: The block count rises on every write slot and falls on every read slot. Once capacity is reached, no write is granted even when the input staging buffer holds a full block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_level | input | LVL_W | Words waiting in the input staging FIFO |
| out_space | input | LVL_W | Free words in the output staging FIFO |
| slot_start | output | 1 | One-cycle pulse marking a new slot decision |
| slot_op | output | 2 | Slot operation: 0 idle, 1 write, 2 read, 3 refresh |
| slot_bank | output | BANK_BITS | Bank part of the block address |
| slot_row | output | BLK_W-BANK_BITS | Upper part of the block address |

## Verification
The bench fills the store until it is full while data keeps arriving. A count that is off by one would then grant one extra write, or stop one block early. It also drains the store to empty while the output side has room, which catches a read granted from an empty store. Input levels of exactly 15 and 16 words probe the eligibility edge; an inclusive or exclusive mix-up shows up there as a slot granted too early or too late. Periods where both data moves are eligible expose a fixed-priority arbiter as a run of same-direction slots. Refresh deadlines that land in those periods show whether refresh really pre-empts data traffic and whether the timer reloads at the grant rather than at expiry. The pointers wrap several times, so a bank split taken from the wrong bits, or a pointer that fails to wrap, shows up as an address mismatch.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_READ    = 2'd2,
    OP_REFRESH = 2'd3
  } slot_op_e;

  typedef struct packed {
    logic slotEdge;
    logic doWrite;
    logic doRead;
    logic doRefresh;
  } sfa_strobe_t;

endpackage

// File: rtl/sfa_ctrl.sv
module sfa_ctrl
  import sfa_pkg::*;
#(
  parameter int SLOT_LEN     = 21,
  parameter int BLOCK_WORDS  = 16,
  parameter int REF_INTERVAL = 1560,
  parameter int LVL_W        = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] inLevel,
  input  logic [LVL_W-1:0] outSpace,
  input  logic             full,
  input  logic             empty,
  output sfa_strobe_t      strb
);

  localparam int SC_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
  localparam int RT_W = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [SC_W-1:0]  SLOT_LAST  = SC_W'(SLOT_LEN - 1);
  localparam logic [RT_W-1:0]  REF_RELOAD = RT_W'(REF_INTERVAL - 1);
  localparam logic [LVL_W-1:0] BLK_LVL    = LVL_W'(BLOCK_WORDS);

  logic [SC_W-1:0] slotCnt;
  logic [RT_W-1:0] refTimer;
  logic            lastWasRead;
  logic            slotEdge;
  logic            refDue;
  logic            wrOk;
  logic            rdOk;

  assign slotEdge = (slotCnt == SLOT_LAST);
  assign refDue   = (refTimer == '0);
  assign wrOk     = (inLevel >= BLK_LVL) && !full;
  assign rdOk     = (outSpace >= BLK_LVL) && !empty;

  // slot sequencing: the counter starts at its last value so that the
  // first decision is taken on the first edge after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotCnt <= SLOT_LAST;
    end else if (slotEdge) begin
      slotCnt <= '0;
    end else begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  // refresh interval timer, reloaded only by a granted refresh slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refTimer <= REF_RELOAD;
    end else if (strb.doRefresh) begin
      refTimer <= REF_RELOAD;
    end else if (!refDue) begin
      refTimer <= refTimer - 1'b1;
    end
  end

  // remembers the direction of the last data slot for alternation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastWasRead <= 1'b1;
    end else if (strb.doWrite) begin
      lastWasRead <= 1'b0;
    end else if (strb.doRead) begin
      lastWasRead <= 1'b1;
    end
  end

  // decision for the next slot
  always_comb begin
    strb          = '0;
    strb.slotEdge = slotEdge;
    if (slotEdge) begin
      if (refDue) begin
        strb.doRefresh = 1'b1;
      end else if (wrOk && rdOk) begin
        strb.doWrite = lastWasRead;
        strb.doRead  = !lastWasRead;
      end else if (wrOk) begin
        strb.doWrite = 1'b1;
      end else if (rdOk) begin
        strb.doRead = 1'b1;
      end
    end
  end

  // R2
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.doWrite, strb.doRead, strb.doRefresh}));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.doWrite |-> !full);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.doRead |-> !empty);

  // R3
  refresh_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.doRefresh |=> (refTimer == REF_RELOAD));

  // R7
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.doWrite && rdOk) |=> !lastWasRead);

endmodule

// File: rtl/sfa_dp.sv
module sfa_dp
  import sfa_pkg::*;
#(
  parameter int BLK_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sfa_strobe_t       strb,
  output logic              full,
  output logic              empty,
  output logic              slotStart,
  output slot_op_e          slotOp,
  output logic [BLK_W-1:0]  slotAddr
);

  localparam int CNT_W = BLK_W + 1;
  localparam logic [CNT_W-1:0] CAP = {1'b1, {BLK_W{1'b0}}};

  logic [BLK_W-1:0] wrPtr;
  logic [BLK_W-1:0] rdPtr;
  logic [CNT_W-1:0] blkCount;

  assign full  = (blkCount == CAP);
  assign empty = (blkCount == '0);

  // block pointers wrap naturally at 2**BLK_W
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      blkCount <= '0;
    end else begin
      if (strb.doWrite) begin
        wrPtr    <= wrPtr + 1'b1;
        blkCount <= blkCount + 1'b1;
      end else if (strb.doRead) begin
        rdPtr    <= rdPtr + 1'b1;
        blkCount <= blkCount - 1'b1;
      end
    end
  end

  // slot request towards the burst sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotStart <= 1'b0;
      slotOp    <= OP_IDLE;
      slotAddr  <= '0;
    end else begin
      slotStart <= strb.slotEdge;
      if (strb.slotEdge) begin
        if (strb.doRefresh) begin
          slotOp   <= OP_REFRESH;
          slotAddr <= '0;
        end else if (strb.doWrite) begin
          slotOp   <= OP_WRITE;
          slotAddr <= wrPtr;
        end else if (strb.doRead) begin
          slotOp   <= OP_READ;
          slotAddr <= rdPtr;
        end else begin
          slotOp   <= OP_IDLE;
          slotAddr <= '0;
        end
      end
    end
  end

  // R10
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blkCount <= CAP);

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.doRead |=> (blkCount == $past(blkCount) - 1'b1));

  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slotStart |=> !slotStart);

  // R2
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.slotEdge |=> $stable(slotOp));

  // R8
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slotOp == OP_IDLE || slotOp == OP_REFRESH) |-> (slotAddr == '0));

endmodule

// File: rtl/sdram_fifo_arbiter.sv
module sdram_fifo_arbiter
  import sfa_pkg::*;
#(
  parameter int SLOT_LEN     = 21,
  parameter int BLOCK_WORDS  = 16,
  parameter int BLK_W        = 18,
  parameter int BANK_BITS    = 2,
  parameter int REF_INTERVAL = 1560,
  parameter int LVL_W        = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LVL_W-1:0]           in_level,
  input  logic [LVL_W-1:0]           out_space,
  output logic                       slot_start,
  output logic [1:0]                 slot_op,
  output logic [BANK_BITS-1:0]       slot_bank,
  output logic [BLK_W-BANK_BITS-1:0] slot_row
);

  sfa_strobe_t      strb;
  logic             full;
  logic             empty;
  slot_op_e         slotOp;
  logic [BLK_W-1:0] slotAddr;

  sfa_ctrl #(
    .SLOT_LEN    (SLOT_LEN),
    .BLOCK_WORDS (BLOCK_WORDS),
    .REF_INTERVAL(REF_INTERVAL),
    .LVL_W       (LVL_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inLevel (in_level),
    .outSpace(out_space),
    .full    (full),
    .empty   (empty),
    .strb    (strb)
  );

  sfa_dp #(
    .BLK_W(BLK_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .full     (full),
    .empty    (empty),
    .slotStart(slot_start),
    .slotOp   (slotOp),
    .slotAddr (slotAddr)
  );

  // bank bits form the least significant part of the block address
  assign slot_op   = slotOp;
  assign slot_bank = slotAddr[BANK_BITS-1:0];
  assign slot_row  = slotAddr[BLK_W-1:BANK_BITS];

endmodule

// File: tb/sim_sdram_fifo_arbiter.sv
module sim_sdram_fifo_arbiter;

  localparam int SLOT    = 21;
  localparam int BWORDS  = 16;
  localparam int BW      = 4;
  localparam int BANKB   = 2;
  localparam int REFI    = 150;
  localparam int LW      = 10;
  localparam int CAP     = 1 << BW;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [LW-1:0]       in_level = '0;
  logic [LW-1:0]       out_space = '0;
  logic                slot_start;
  logic [1:0]          slot_op;
  logic [BANKB-1:0]    slot_bank;
  logic [BW-BANKB-1:0] slot_row;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // behavioural model state
  int mSlot = SLOT - 1;
  int mRef  = REFI - 1;
  int mCount = 0;
  int mLastRead = 1;
  int wrQ[$];
  int rdNext = 0;
  int wrNext = 0;
  int expStart = 0;
  int expOp = 0;
  int expAddr = 0;
  string opTag = "R2";

  always #10 clk = ~clk;

  sdram_fifo_arbiter #(
    .SLOT_LEN(SLOT), .BLOCK_WORDS(BWORDS), .BLK_W(BW), .BANK_BITS(BANKB),
    .REF_INTERVAL(REFI), .LVL_W(LW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .in_level(in_level), .out_space(out_space),
    .slot_start(slot_start), .slot_op(slot_op),
    .slot_bank(slot_bank), .slot_row(slot_row)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    check("R1 slot_start", int'(slot_start), expStart);
    check({opTag, " slot_op"}, int'(slot_op), expOp);
    check("R8 address", int'({slot_row, slot_bank}), expAddr);
    check("R9 bank", int'(slot_bank), expAddr % (1 << BANKB));
    check("R9 row", int'(slot_row), expAddr >> BANKB);
  endtask

  // predicts the outputs after the coming rising edge
  task automatic modelStep(input int il, input int os);
    bit we, re;
    expStart = 0;
    if (mSlot == SLOT - 1) begin
      mSlot = 0;
      expStart = 1;
      we = (il >= BWORDS) && (mCount < CAP);
      re = (mCount > 0) && (os >= BWORDS);
      if (mRef == 0) begin
        expOp = 3; expAddr = 0; opTag = "R3"; mRef = REFI - 1;
      end else begin
        mRef--;
        if (we && re) begin
          expOp = mLastRead ? 1 : 2; opTag = "R7";
        end else if (we) begin
          expOp = 1; opTag = "R5";
        end else if (re) begin
          expOp = 2; opTag = "R6";
        end else begin
          expOp = 0; opTag = (il >= BWORDS) ? "R10" : "R4";
        end
        if (expOp == 1) begin
          expAddr = wrNext; wrQ.push_back(wrNext);
          wrNext = (wrNext + 1) % CAP; mCount++; mLastRead = 0;
        end else if (expOp == 2) begin
          expAddr = wrQ.pop_front(); rdNext = (rdNext + 1) % CAP;
          mCount--; mLastRead = 1;
        end else begin
          expAddr = 0;
        end
      end
    end else begin
      mSlot++;
      opTag = "R2";
      if (mRef > 0) mRef--;
    end
  endtask

  task automatic runCycles(input int n, input int il, input int os, input bit rnd);
    for (int i = 0; i < n; i++) begin
      int a, b;
      a = rnd ? int'($urandom_range(0, 40)) : il;
      b = rnd ? int'($urandom_range(0, 40)) : os;
      compareAll();
      in_level  = LW'(a);
      out_space = LW'(b);
      modelStep(a, b);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 reset slot_start", int'(slot_start), 0);
    check("R2 reset slot_op", int'(slot_op), 0);
    rst_n = 1'b1;
    runCycles(400, 0, 0, 0);      // R4 idle slots and R3 refreshes
    runCycles(300, 15, 40, 0);    // one word short: still idle
    runCycles(600, 16, 0, 0);     // R5 writes until full, R10 blocks
    runCycles(400, 40, 40, 0);    // R7 alternation at full
    runCycles(900, 0, 16, 0);     // R6 drain to empty, R8 wrap
    runCycles(800, 20, 20, 0);    // R7 alternation with refresh
    runCycles(4000, 0, 0, 1);     // mixed levels
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule